// File: doc/BRIEF.md
# Cascadable LCD segment data driver

This block is the digital core of a 40-output LCD segment driver. Serial segment data arrives on two inputs, one for each 20-bit half of a shift register. Both halves advance by one position on each falling edge of the shift clock. Each half presents its last stage on a serial output. Tying the lower serial output to the upper serial input forms a single 40-bit chain. The upper serial output can feed the next driver in a cascade.

A holding latch sits between the shift register and the outputs. While the load input is high the latch is transparent, so the outputs follow the shift register. While load is low the latch keeps its contents, even if the shift register keeps moving. This lets a controller stream the next frame of segment data while the current frame stays on the glass.

Each latched bit is combined with the AC-drive polarity input to pick one of four drive levels. The level is reported as a 2-bit code per segment. The code path has no register, so a polarity change reaches all 40 codes without any clock edge. The analog switches and the LCD supply rails are outside this block.

Top module: `seg_drv_core`

## Requirements
- R1: An active-low asynchronous reset clears the shift register and the latch to zero. During and after reset, with polarity 0, every segment code is 01 and both serial outputs are 0.
- R2: On each falling edge of `cp` the lower half moves by exactly one position. Bit 1 (segment 1, code bits [1:0]) takes `di_lo`.
- R3: `do_lo` shows bit 20 and `do_hi` shows bit 40. Both change only on a falling edge of `cp`.
- R4: With `do_lo` looped to `di_hi`, 40 falling edges form one 40-bit chain. The first bit shifted in ends at segment 40 and the last at segment 1.
- R5: While `load` is high the latch is transparent. This includes the case where a shift edge falls while load is high: the codes then show the post-shift contents.
- R6: While `load` is low, further shifting leaves all segment codes unchanged.
- R7: Segment n uses code bits [2n-1:2n-2]. The codes are 00 for the top supply, 01 for the upper middle level, 10 for the lower middle level and 11 for the bottom level. The mapping from latch bit and polarity is:
  - latch 1 with polarity 0 gives 00
  - latch 0 with polarity 0 gives 01
  - latch 0 with polarity 1 gives 10
  - latch 1 with polarity 1 gives 11
- R8: A change on `df` updates all 40 codes without any `cp` edge.
- R9: Bit 21 (segment 21) takes `di_hi`. The upper half is fed independently of the lower half when the two are not chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp | input | 1 | Shift clock, active on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| di_lo | input | 1 | Serial data into bit 1 |
| di_hi | input | 1 | Serial data into bit 21 |
| load | input | 1 | High: latch transparent; low: latch holds |
| df | input | 1 | AC-drive polarity |
| do_lo | output | 1 | Serial output of bit 20 |
| do_hi | output | 1 | Serial output of bit 40 |
| seg_code | output | 80 | Drive-level code, 2 bits per segment |

## Verification
A shift and a latch transfer can fall in the same cycle when `load` is held high across a falling `cp` edge. The bench provokes this from a cleared state by shifting a single 1 with load high. It then judges the codes at once, before any further edge: segment 1 must already show the new bit at the shifted position. A polarity change can also coincide with held data. The bench flips `df` with no clock running and expects every code to move to the other polarity row of the mapping.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    LVL_TOP    = 2'b00,
    LVL_UPMID  = 2'b01,
    LVL_LOWMID = 2'b10,
    LVL_BOTTOM = 2'b11
  } drive_lvl_e;

  // Level pick from one held segment bit and the AC polarity
  function automatic drive_lvl_e pick_level(input logic seg_bit, input logic pol);
    drive_lvl_e lvl;
    unique case ({seg_bit, pol})
      2'b10:   lvl = LVL_TOP;
      2'b00:   lvl = LVL_UPMID;
      2'b01:   lvl = LVL_LOWMID;
      default: lvl = LVL_BOTTOM;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/seg_shift_half.sv
module seg_shift_half #(
  parameter int WIDTH = 20
) (
  input  logic             cp,
  input  logic             rst_n,
  input  logic             din,
  output logic [WIDTH-1:0] q,
  output logic             dout
);

  logic armed;

  always_ff @(negedge cp or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= {q[WIDTH-2:0], din};
      armed <= 1'b1;
    end
  end

  // named tap of the last stage
  assign dout = q[WIDTH-1];

  // R2: first stage takes the serial input present at the previous edge
  p_entry_r2: assert property (@(negedge cp) disable iff (!rst_n)
    armed |-> (q[0] == $past(din)));

  // R3: serial output carries what the stage before it held one edge earlier
  p_serial_out_r3: assert property (@(negedge cp) disable iff (!rst_n)
    armed |-> (dout == $past(q[WIDTH-2])));

endmodule

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int WIDTH = 40
) (
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_latch begin
    if (!rst_n)    q = '0;
    else if (load) q = d;
  end

endmodule

// File: rtl/seg_level_sel.sv
module seg_level_sel
  import lcd_seg_pkg::*;
#(
  parameter int SEGS = 40
) (
  input  logic                  pol,
  input  logic [SEGS-1:0]       held,
  output logic [SEGS*CODE_W-1:0] codes
);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    drive_lvl_e lvl;
    always_comb lvl = pick_level(held[s], pol);
    assign codes[s*CODE_W +: CODE_W] = lvl;
  end

endmodule

// File: rtl/seg_drv_core.sv
module seg_drv_core
  import lcd_seg_pkg::*;
#(
  parameter int HALF_W = 20
) (
  input  logic                       cp,
  input  logic                       rst_n,
  input  logic                       di_lo,
  input  logic                       di_hi,
  input  logic                       load,
  input  logic                       df,
  output logic                       do_lo,
  output logic                       do_hi,
  output logic [2*HALF_W*CODE_W-1:0] seg_code
);

  localparam int SEGS  = 2 * HALF_W;
  localparam int HALVES = 2;

  logic [HALVES-1:0]   half_in;
  logic [HALVES-1:0]   half_out;
  logic [SEGS-1:0]     shift_q;
  logic [SEGS-1:0]     held_q;
  logic                armed;

  assign half_in = {di_hi, di_lo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    seg_shift_half #(.WIDTH(HALF_W)) u_half (
      .cp   (cp),
      .rst_n(rst_n),
      .din  (half_in[h]),
      .q    (shift_q[h*HALF_W +: HALF_W]),
      .dout (half_out[h])
    );
  end

  assign do_lo = half_out[0];
  assign do_hi = half_out[1];

  seg_hold_latch #(.WIDTH(SEGS)) u_latch (
    .rst_n(rst_n),
    .load (load),
    .d    (shift_q),
    .q    (held_q)
  );

  seg_level_sel #(.SEGS(SEGS)) u_sel (
    .pol  (df),
    .held (held_q),
    .codes(seg_code)
  );

  always_ff @(negedge cp or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R5: with load high the held word matches the shift register
  p_follow_r5: assert property (@(negedge cp) disable iff (!rst_n)
    load |-> (held_q == shift_q));

  // R7: the upper code bit of segment 1 tracks the polarity input
  p_df_polarity_r7: assert property (@(negedge cp) disable iff (!rst_n)
    armed |-> (seg_code[1] == df));

endmodule

// File: tb/tb_seg_drv_core.sv
module tb_seg_drv_core;

  localparam int HALF_W = 20;
  localparam int SEGS   = 2 * HALF_W;
  localparam int CW     = 2 * SEGS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic cp = 1'b0, rst_n = 1'b0, di_lo = 1'b0, di_hi_drv = 1'b0;
  logic load = 1'b0, df = 1'b0, chain = 1'b0;
  logic di_hi_w, do_lo, do_hi;
  logic [CW-1:0] seg_code;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign di_hi_w = chain ? do_lo : di_hi_drv;

  seg_drv_core #(.HALF_W(HALF_W)) dut (
    .cp(cp), .rst_n(rst_n), .di_lo(di_lo), .di_hi(di_hi_w),
    .load(load), .df(df), .do_lo(do_lo), .do_hi(do_hi), .seg_code(seg_code)
  );

  localparam logic [SEGS-1:0] PATS [4] = '{
    40'h80_0000_0001, 40'hA5_5AF0_0F3C, 40'hFF_FFFF_FFFF, 40'h12_3456_789A
  };

  // upper bit copies polarity; lower bit set when latch bit equals polarity
  function automatic logic [CW-1:0] expect_codes(input logic [SEGS-1:0] lat, input logic pol);
    logic [CW-1:0] e;
    for (int i = 0; i < SEGS; i++) begin
      e[2*i+1] = pol;
      e[2*i]   = (lat[i] == pol);
    end
    return e;
  endfunction

  task automatic chk_bus(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic lo, input logic hi);
    di_lo = lo;
    di_hi_drv = hi;
    @(posedge clk); cp = 1'b1;
    @(negedge clk); cp = 1'b0;
    #1;
  endtask

  task automatic pulse_load();
    @(posedge clk); #1 load = 1'b1;
    @(posedge clk); #1 load = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    chk_bus("R1 codes in reset", seg_code, expect_codes('0, 1'b0));
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk_bus("R1 codes after reset", seg_code, expect_codes('0, 1'b0));
    chk_bit("R1 do_lo", do_lo, 1'b0);
    chk_bit("R1 do_hi", do_hi, 1'b0);

    // R2 R5: shift with load high, transfer and shift coincide
    load = 1'b1;
    shift_bit(1'b1, 1'b0);
    chk_bus("R2 R5 one step, transparent", seg_code, expect_codes(40'h1, 1'b0));
    shift_bit(1'b0, 1'b0);
    chk_bus("R2 exactly one position", seg_code, expect_codes(40'h2, 1'b0));
    load = 1'b0;

    // Table walk: R4 R7 R3 with chained halves
    chain = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int i = SEGS - 1; i >= 0; i--) shift_bit(PATS[p][i], 1'b0);
      chk_bit("R3 do_lo is bit 20", do_lo, PATS[p][HALF_W-1]);
      chk_bit("R3 do_hi is bit 40", do_hi, PATS[p][SEGS-1]);
      pulse_load();
      df = 1'b0; #1;
      chk_bus("R4 R7 chain, polarity 0", seg_code, expect_codes(PATS[p], 1'b0));
      df = 1'b1; #1;
      chk_bus("R4 R7 chain, polarity 1", seg_code, expect_codes(PATS[p], 1'b1));
      df = 1'b0;
    end

    // R6: shifting with load low leaves outputs unchanged
    for (int i = 0; i < 9; i++) shift_bit(i[0], 1'b0);
    chk_bus("R6 hold while shifting", seg_code, expect_codes(PATS[3], 1'b0));

    // R8: polarity flip with no clock
    df = 1'b1; #1;
    chk_bus("R8 df change without clock", seg_code, expect_codes(PATS[3], 1'b1));
    df = 1'b0; #1;
    chk_bus("R8 df back without clock", seg_code, expect_codes(PATS[3], 1'b0));

    // R9: independent halves
    chain = 1'b0;
    begin
      logic [HALF_W-1:0] a, b;
      a = 20'hF00F1;
      b = 20'h0C3A5;
      for (int i = HALF_W - 1; i >= 0; i--) shift_bit(a[i], b[i]);
      pulse_load();
      chk_bus("R9 independent halves", seg_code, expect_codes({b, a}, 1'b0));
      chk_bit("R9 do_hi top of upper half", do_hi, b[HALF_W-1]);
    end

    // R1: reset mid-run clears loaded data
    #1 rst_n = 1'b0; #1;
    chk_bus("R1 async reset clears", seg_code, expect_codes('0, 1'b0));
    chk_bit("R1 do_hi cleared", do_hi, 1'b0);
    #1 rst_n = 1'b1;

    finish_run();
  end

endmodule